// File: doc/BRIEF.md
# Baseband Low-Power Mode Sequencer

This block decides when a wireless baseband may drop into one of three low-power levels and brings it back out safely. It watches two activity indications, one from the radio link scheduler and one from the host side, and counts consecutive idle cycles against a programmable limit. When the limit is reached it chooses between a light sleep, in which the baseband clock keeps running, and a deep sleep, in which the baseband clock is gated and the platform system clock request is dropped. Deep sleep is locked out after reset and becomes selectable only through a configuration write. It is also refused while data is pending on the host transport, and the block then takes light sleep instead.

A complete power-down level is entered only on an explicit host command. Leaving deep sleep can be started by the host or by a device-side event. Leaving power-down can be started only by the host. After deep sleep or power-down, the block raises the clock request again and waits until the platform reports a stable clock before it returns to active. The last source that woke the block is reported at the ports.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset `lp_mode` is 0 (active), `bb_clk_en` is 1, `sys_clk_req` is 1 and `wake_src` is 0. The `lp_mode` codes are: 0 active, 1 light sleep, 2 deep sleep, 3 power-down, 4 waiting for clock.
- R2: Deep sleep cannot be chosen after reset. A cycle with `deep_cfg_we` high stores `deep_cfg_val` as the deep-sleep enable, and the stored value is used from the next clock edge.
- R3: Power-down (3) is entered only from a clock edge at which `host_pdown_req` is high. The request is taken in active, light sleep or deep sleep, and it wins over any wake request at that edge. In power-down, `dev_wake_req` is ignored and only `host_wake_req` leads to the wait-for-clock state (4).
- R4: With both `link_active` and `host_active` low, the block leaves active at the (`idle_limit`+1)-th consecutive clock edge at which both are low. Any activity at an edge restarts the count.
- R5: At that edge the block goes to deep sleep (2) if deep sleep is enabled and both `tx_pending` and `rx_pending` are low. Otherwise it goes to light sleep (1).
- R6: `bb_clk_en` is 1 in active and light sleep, and 0 in deep sleep, power-down and wait-for-clock.
- R7: `sys_clk_req` is 0 in deep sleep and power-down, and 1 in every other mode.
- R8: In light sleep, a host or device wake request at a clock edge returns the block to active (0) at that edge.
- R9: In deep sleep, a host or device wake request moves the block to wait-for-clock (4). The block stays there while `sys_clk_stable` is low and returns to active at the first edge at which it is high.
- R10: `wake_src` reports the source that started the last wake: 1 for host, 2 for device. The host wins when both requests arrive at the same edge. The value holds until the next wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baseband clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_active | input | 1 | Link scheduler has traffic this cycle |
| host_active | input | 1 | Host side has activity this cycle |
| tx_pending | input | 1 | Transmit data pending on the host transport |
| rx_pending | input | 1 | Receive data pending on the host transport |
| deep_cfg_we | input | 1 | Write strobe for the deep-sleep enable |
| deep_cfg_val | input | 1 | Value written to the deep-sleep enable |
| host_pdown_req | input | 1 | Host command to enter power-down |
| host_wake_req | input | 1 | Host wake request |
| dev_wake_req | input | 1 | Device-side wake event |
| sys_clk_stable | input | 1 | Platform reports the system clock stable |
| idle_limit | input | CNT_W | Idle cycles required before sleeping |
| lp_mode | output | 3 | Current mode code |
| bb_clk_en | output | 1 | Baseband clock gate enable |
| sys_clk_req | output | 1 | System clock request toward the platform |
| wake_src | output | 2 | Source of the last wake |

## Verification
A wrong idle count shows up as a sleep entry one or more edges early or late, so the bench counts the edges from the last activity to the first change in `lp_mode`. A wrong choice of sleep level appears at that same edge as the wrong mode code, and it also appears on `bb_clk_en` and `sys_clk_req`. A broken wake path shows within one edge of the request: as a mode that does not move, as a premature return to active before the clock is stable, or as the wrong `wake_src`.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        LP_ACTIVE = 3'd0,
        LP_SLEEP  = 3'd1,
        LP_DEEP   = 3'd2,
        LP_PDOWN  = 3'd3,
        LP_WAIT   = 3'd4
    } lp_mode_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_HOST = 2'd1,
        WK_DEV  = 2'd2
    } lp_wake_e;

    typedef struct packed {
        lp_mode_e state;
        logic     deep_en;
        lp_wake_e wake;
    } lp_regs_t;

endpackage

// File: rtl/lpm_idle_cnt.sv
module lpm_idle_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_ok,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = (cnt_q >= limit);

    always_comb begin
        cnt_d = cnt_q;
        if (!idle_ok) begin
            cnt_d = '0;
        end else if (!done) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: a broken idle run clears the count
    p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_ok |=> cnt_q == '0);

    // R4: a nonzero count moves up by one at most
    p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)) || $stable(cnt_q));

endmodule

// File: rtl/lpm_wake_arb.sv
module lpm_wake_arb
    import lpm_pkg::*;
(
    input  logic     host_req,
    input  logic     dev_req,
    input  logic     dev_allowed,
    output logic     fire,
    output lp_wake_e src
);

    always_comb begin
        fire = host_req | (dev_req & dev_allowed);
        if (host_req) src = WK_HOST;
        else          src = WK_DEV;
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_active,
    input  logic             host_active,
    input  logic             tx_pending,
    input  logic             rx_pending,
    input  logic             deep_cfg_we,
    input  logic             deep_cfg_val,
    input  logic             host_pdown_req,
    input  logic             host_wake_req,
    input  logic             dev_wake_req,
    input  logic             sys_clk_stable,
    input  logic [CNT_W-1:0] idle_limit,
    output logic [2:0]       lp_mode,
    output logic             bb_clk_en,
    output logic             sys_clk_req,
    output logic [1:0]       wake_src
);

    lp_regs_t r_d, r_q;

    logic     idle_now;
    logic     idle_done;
    logic     wake_fire;
    lp_wake_e wake_pick;
    logic     deep_ok;

    assign idle_now = !link_active && !host_active;
    assign deep_ok  = r_q.deep_en && !tx_pending && !rx_pending;

    lpm_idle_cnt #(.CNT_W(CNT_W)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle_ok(idle_now && (r_q.state == LP_ACTIVE)),
        .limit  (idle_limit),
        .done   (idle_done)
    );

    lpm_wake_arb u_arb (
        .host_req   (host_wake_req),
        .dev_req    (dev_wake_req),
        .dev_allowed(r_q.state != LP_PDOWN),
        .fire       (wake_fire),
        .src        (wake_pick)
    );

    always_comb begin
        r_d = r_q;
        if (deep_cfg_we) r_d.deep_en = deep_cfg_val;
        unique case (r_q.state)
            LP_ACTIVE: begin
                if (host_pdown_req) begin
                    r_d.state = LP_PDOWN;
                end else if (idle_now && idle_done) begin
                    r_d.state = deep_ok ? LP_DEEP : LP_SLEEP;
                end
            end
            LP_SLEEP: begin
                if (host_pdown_req) begin
                    r_d.state = LP_PDOWN;
                end else if (wake_fire) begin
                    r_d.state = LP_ACTIVE;
                    r_d.wake  = wake_pick;
                end
            end
            LP_DEEP: begin
                if (host_pdown_req) begin
                    r_d.state = LP_PDOWN;
                end else if (wake_fire) begin
                    r_d.state = LP_WAIT;
                    r_d.wake  = wake_pick;
                end
            end
            LP_PDOWN: begin
                if (wake_fire) begin
                    r_d.state = LP_WAIT;
                    r_d.wake  = wake_pick;
                end
            end
            LP_WAIT: begin
                if (sys_clk_stable) r_d.state = LP_ACTIVE;
            end
            default: r_d.state = LP_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= LP_ACTIVE;
            r_q.deep_en <= 1'b0;
            r_q.wake    <= WK_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        lp_mode     = r_q.state;
        wake_src    = r_q.wake;
        bb_clk_en   = (r_q.state == LP_ACTIVE) || (r_q.state == LP_SLEEP);
        sys_clk_req = (r_q.state != LP_DEEP) && (r_q.state != LP_PDOWN);
    end

    // R2: deep sleep is entered only while enabled
    p_deep_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == LP_DEEP && $past(r_q.state) != LP_DEEP) |-> $past(r_q.deep_en));

    // R3: power-down is entered only on the host command
    p_pdown_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == LP_PDOWN && $past(r_q.state) != LP_PDOWN) |-> $past(host_pdown_req));

    // R3: power-down is left only on a host wake
    p_pdown_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.state) == LP_PDOWN && r_q.state != LP_PDOWN) |-> $past(host_wake_req));

    // R5: no deep sleep while transport data is pending
    p_deep_no_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == LP_DEEP && $past(r_q.state) == LP_ACTIVE)
        |-> (!$past(tx_pending) && !$past(rx_pending)));

    // R8: light sleep returns straight to active on a wake
    p_sleep_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == LP_SLEEP && !host_pdown_req && (host_wake_req || dev_wake_req))
        |=> r_q.state == LP_ACTIVE);

    // R9: the wait-for-clock state holds until the clock is stable
    p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == LP_WAIT && !sys_clk_stable) |=> r_q.state == LP_WAIT);

    // R10: a host wake is reported as the host source
    p_host_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == LP_SLEEP || r_q.state == LP_DEEP || r_q.state == LP_PDOWN)
         && !host_pdown_req && host_wake_req) |=> r_q.wake == WK_HOST);

endmodule

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;

    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_active = 1'b1, host_active = 1'b0;
    logic tx_pending = 1'b0, rx_pending = 1'b0;
    logic deep_cfg_we = 1'b0, deep_cfg_val = 1'b0;
    logic host_pdown_req = 1'b0, host_wake_req = 1'b0, dev_wake_req = 1'b0;
    logic sys_clk_stable = 1'b0;
    logic [CNT_W-1:0] idle_limit = '0;
    logic [2:0] lp_mode;
    logic bb_clk_en, sys_clk_req;
    logic [1:0] wake_src;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lpm_ctrl #(.CNT_W(CNT_W)) u_lpm_ctrl (
        .clk(clk), .rst_n(rst_n),
        .link_active(link_active), .host_active(host_active),
        .tx_pending(tx_pending), .rx_pending(rx_pending),
        .deep_cfg_we(deep_cfg_we), .deep_cfg_val(deep_cfg_val),
        .host_pdown_req(host_pdown_req), .host_wake_req(host_wake_req),
        .dev_wake_req(dev_wake_req), .sys_clk_stable(sys_clk_stable),
        .idle_limit(idle_limit), .lp_mode(lp_mode), .bb_clk_en(bb_clk_en),
        .sys_clk_req(sys_clk_req), .wake_src(wake_src)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic chk_outs(input string req, input int mode);
        chk({req, " mode"}, lp_mode, mode);
        chk({req, " R6 gate"}, bb_clk_en, (mode == 0 || mode == 1) ? 1 : 0);
        chk({req, " R7 req"}, sys_clk_req, (mode == 2 || mode == 3) ? 0 : 1);
    endtask

    task automatic set_deep(input logic v);
        deep_cfg_we = 1'b1; deep_cfg_val = v;
        step();
        deep_cfg_we = 1'b0;
    endtask

    // drop activity and count edges until the mode changes
    task automatic run_idle(output int edges);
        link_active = 1'b0; host_active = 1'b0;
        edges = 0;
        do begin
            step();
            edges++;
        end while (lp_mode == 3'd0 && edges < 40);
    endtask

    task automatic finish_deep(input string req, input int src);
        step();
        host_wake_req = 1'b0; dev_wake_req = 1'b0;
        chk_outs({req, " R9 wait"}, 4);
        for (int k = 0; k < 2; k++) begin
            step();
            chk({req, " R9 hold"}, lp_mode, 4);
        end
        sys_clk_stable = 1'b1;
        step();
        sys_clk_stable = 1'b0;
        chk_outs({req, " R9 back"}, 0);
        chk({req, " R10 src"}, wake_src, src);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run ended)");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int edges;
        int idx;
        int exp_mode;
        int exp_src;
        #35 rst_n = 1'b1;
        #1;
        chk_outs("R1 reset", 0);
        chk("R1 wake_src", wake_src, 0);

        // R2: deep sleep locked after reset
        idle_limit = 8'd1;
        link_active = 1'b1; step();
        run_idle(edges);
        chk("R2 locked", lp_mode, 1);
        dev_wake_req = 1'b1; link_active = 1'b1; step(); dev_wake_req = 1'b0;
        chk("R8 dev wake", lp_mode, 0);
        chk("R10 dev src", wake_src, 2);

        // R4/R5/R8/R9/R10 sweep
        idx = 0;
        for (int t = 0; t < 5; t++) begin
            for (int en = 0; en < 2; en++) begin
                for (int p = 0; p < 4; p++) begin
                    idle_limit = CNT_W'(t);
                    link_active = 1'b1;
                    set_deep(en[0]);
                    tx_pending = p[0]; rx_pending = p[1];
                    step();
                    run_idle(edges);
                    chk("R4 idle edges", edges, t + 1);
                    exp_mode = (en == 1 && p == 0) ? 2 : 1;
                    chk_outs("R5 target", exp_mode);
                    link_active = 1'b1;
                    tx_pending = 1'b0; rx_pending = 1'b0;
                    host_wake_req = (idx % 3 != 1);
                    dev_wake_req  = (idx % 3 != 0);
                    exp_src = (idx % 3 == 1) ? 2 : 1;
                    if (exp_mode == 1) begin
                        step();
                        host_wake_req = 1'b0; dev_wake_req = 1'b0;
                        chk_outs("R8 exit", 0);
                        chk("R10 src", wake_src, exp_src);
                    end else begin
                        finish_deep("sweep", exp_src);
                    end
                    idx++;
                end
            end
        end

        // R4: activity in the middle restarts the count
        idle_limit = 8'd3;
        set_deep(1'b0);
        link_active = 1'b0;
        step(); step();
        chk("R4 still active", lp_mode, 0);
        host_active = 1'b1; step(); host_active = 1'b0;
        run_idle(edges);
        chk("R4 restart edges", edges, 4);
        link_active = 1'b1; host_wake_req = 1'b1; step(); host_wake_req = 1'b0;

        // R3: power-down from active, device wake ignored
        host_pdown_req = 1'b1; dev_wake_req = 1'b1; step(); host_pdown_req = 1'b0;
        chk_outs("R3 pdown", 3);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R3 dev ignored", lp_mode, 3);
        end
        dev_wake_req = 1'b0;
        host_wake_req = 1'b1;
        finish_deep("R3 host exit", 1);

        // R3: power-down from deep sleep wins over a wake
        idle_limit = 8'd0;
        set_deep(1'b1);
        run_idle(edges);
        chk("R5 deep", lp_mode, 2);
        link_active = 1'b1;
        host_pdown_req = 1'b1; dev_wake_req = 1'b1; step();
        host_pdown_req = 1'b0; dev_wake_req = 1'b0;
        chk_outs("R3 pdown from deep", 3);
        host_wake_req = 1'b1;
        finish_deep("R3 exit2", 1);

        // R3: power-down from light sleep
        set_deep(1'b0);
        run_idle(edges);
        chk("R2 disabled again", lp_mode, 1);
        host_pdown_req = 1'b1; host_wake_req = 1'b1; step();
        host_pdown_req = 1'b0; host_wake_req = 1'b0;
        chk_outs("R3 pdown from sleep", 3);
        host_wake_req = 1'b1; link_active = 1'b1;
        finish_deep("R3 exit3", 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule